// File: doc/BRIEF.md
# Super I/O Configuration Registers with GPIO Window Decode

This block holds the configuration state of a multi-function peripheral controller and places its general-purpose I/O data port in the I/O map. A host reaches the configuration space through two adjacent I/O addresses. The lower address selects a register. The upper address carries the data for that register. A value is stored only when the host writes the data address twice in a row. A single stray write therefore cannot reconfigure the device.

Two of the stored registers control where the GPIO port sits. One of them sets the base address of a small window. Two bits of the other turn on each of the two GPIO bytes independently. When either register changes, the old decode is dropped and the new one takes effect on the next access. Each enabled GPIO byte is an 8-bit latch that the host can write and read back. The block also reports, one cycle later, every bus access that landed on an enabled GPIO byte. The pin drivers and the other peripheral functions are outside this block; only their configuration bytes are stored here.

Top module: `sio_cfg_gpio`

## Requirements
- R1: A write to the data address (CFG_BASE+1) only arms the block. The next write to the data address stores the value into the selected register and disarms the block. Idle cycles, data-address reads and GPIO accesses between the two writes do not disarm it.
- R2: A write to the index address (CFG_BASE) sets the 8-bit register index. A read of the index address returns the index. Any read or write of the index address disarms a pending commit.
- R3: Register 8 always reads CHIP_ID (default 0x70) and register 24 always reads 0x00. Host writes change neither of them. Indices 29 and above store nothing, and the data address reads 0xFF at those indices. Index 28 is still a writable register.
- R4: A committed write to register 0 stores the written value ANDed with 0x5F.
- R5: After reset, all registers read 0x00 except register 8, and the index is 0. The block is disarmed, both GPIO latches hold 0x00, bus_rdata is 0x00 and gpio_hit is 0.
- R6: GPIO byte 0 sits at address {reg15, 2'b00} and is enabled by bit 4 of register 18. Byte 1 sits at that address plus 1 and is enabled by bit 5 of register 18. A committed change to register 15 or 18 governs the very next bus access, and the old location stops decoding.
- R7: A write to an enabled GPIO byte loads its latch (gpio_latch[7:0] for byte 0, [15:8] for byte 1). A read returns the latch. A write to a disabled byte changes nothing, and a read of it returns 0xFF.
- R8: gpio_hit is high in the cycle after a read or write that hit an enabled GPIO byte. If the GPIO window overlaps the two configuration addresses, the configuration access wins and gpio_hit stays low.
- R9: bus_rdata is registered. It updates one cycle after a read strobe and holds its value otherwise. A read of an address that nothing claims returns 0xFF. When bus_wr and bus_rd are high together, only the write takes effect and bus_rdata holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW (16) | I/O address of the current access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| gpio_hit | output | 1 | Registered flag: the last access hit an enabled GPIO byte |
| gpio_latch | output | 16 | GPIO data latches, byte 1 in the upper half |

## Verification
Two decoders can claim one address in the same cycle. Programming register 15 to 0xE6 moves the GPIO window onto the configuration addresses, so the index decode and the GPIO byte-0 decode both match a single access. The bench then writes and reads that shared address and expects index behaviour, an unchanged latch and a low gpio_hit. A behavioural reference model is compared on every clock, which also judges the cycle right after a decode register commits, when the new window must already apply.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int GPIO_BYTES = 2;
  localparam int DW         = 8;
  typedef logic [DW-1:0] byte_t;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_IDX  = 2'd1,
    SRC_DAT  = 2'd2,
    SRC_GPIO = 2'd3
  } rd_src_e;
endpackage

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_pkg::*;
#(
  parameter int    NREG     = 29,
  parameter int    RO_A     = 8,
  parameter int    RO_B     = 24,
  parameter byte_t CHIP_ID  = 8'h70,
  parameter byte_t R0_MASK  = 8'h5F,
  parameter int    BASE_IDX = 15,
  parameter int    EN_IDX   = 18,
  parameter int    EN_LSB   = 4,
  parameter int    NBYTE    = GPIO_BYTES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             idx_wr,
  input  logic             idx_rd,
  input  logic             dat_wr,
  input  byte_t            wdata,
  output byte_t            idx_q,
  output byte_t            dat_rdata,
  output byte_t            gpio_base,
  output logic [NBYTE-1:0] gpio_en
);
  localparam int IW = $clog2(NREG);

  byte_t regs [NREG];
  logic  armed;
  logic  commit;
  logic  in_range;

  assign commit   = dat_wr && armed;
  assign in_range = (idx_q < byte_t'(NREG));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      armed <= 1'b0;
    end else if (idx_wr || idx_rd) begin
      armed <= 1'b0;
      if (idx_wr) idx_q <= wdata;
    end else if (dat_wr) begin
      armed <= !armed;
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == RO_A) begin : g_ro_id
      assign regs[i] = CHIP_ID;
    end else if (i == RO_B) begin : g_ro_zero
      assign regs[i] = '0;
    end else if (i == 0) begin : g_masked
      always_ff @(posedge clk) begin
        if (rst)                              regs[i] <= '0;
        else if (commit && idx_q == byte_t'(i)) regs[i] <= wdata & R0_MASK;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)                              regs[i] <= '0;
        else if (commit && idx_q == byte_t'(i)) regs[i] <= wdata;
      end
    end
  end

  assign dat_rdata = in_range ? regs[idx_q[IW-1:0]] : 8'hFF;
  assign gpio_base = regs[BASE_IDX];
  assign gpio_en   = regs[EN_IDX][EN_LSB +: NBYTE];

  // R1: a data write while disarmed leaves register 0 untouched
  p_first_write_no_commit_r1: assert property (@(posedge clk) disable iff (rst)
    (dat_wr && !armed && idx_q == 8'h00 && !idx_wr && !idx_rd) |=> $stable(regs[0]));

  // R4: an armed write to register 0 stores the masked value
  p_reg0_masked_r4: assert property (@(posedge clk) disable iff (rst)
    (dat_wr && armed && idx_q == 8'h00) |=> (regs[0] == ($past(wdata) & R0_MASK)));
endmodule

// File: rtl/sio_gpio_decode.sv
module sio_gpio_decode
  import sio_pkg::*;
#(
  parameter int AW    = 16,
  parameter int NBYTE = GPIO_BYTES
) (
  input  logic [AW-1:0]    addr,
  input  logic             cfg_claim,
  input  byte_t            base_reg,
  input  logic [NBYTE-1:0] en,
  output logic [NBYTE-1:0] sel
);
  localparam int SHIFT = 2;

  for (genvar k = 0; k < NBYTE; k++) begin : g_byte
    logic [AW-1:0] byte_addr;
    assign byte_addr = AW'({base_reg, SHIFT'(k)});
    assign sel[k]    = !cfg_claim && en[k] && (addr == byte_addr);
  end
endmodule

// File: rtl/sio_gpio_latch.sv
module sio_gpio_latch
  import sio_pkg::*;
#(
  parameter int NBYTE = GPIO_BYTES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [NBYTE-1:0]   sel,
  input  byte_t              wdata,
  output logic [NBYTE*8-1:0] lat
);
  for (genvar k = 0; k < NBYTE; k++) begin : g_lat
    always_ff @(posedge clk) begin
      if (rst)              lat[k*8 +: 8] <= '0;
      else if (wr && sel[k]) lat[k*8 +: 8] <= wdata;
    end

    // R7: a byte changes only when written through its own enabled decode
    p_latch_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !(wr && sel[k]) |=> $stable(lat[k*8 +: 8]));
  end
endmodule

// File: rtl/sio_cfg_gpio.sv
module sio_cfg_gpio
  import sio_pkg::*;
#(
  parameter int            AW       = 16,
  parameter logic [AW-1:0] CFG_BASE = 16'h0398,
  parameter byte_t         CHIP_ID  = 8'h70
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [AW-1:0]        bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  output logic                 gpio_hit,
  output logic [GPIO_BYTES*8-1:0] gpio_latch
);
  localparam int NB = GPIO_BYTES;

  logic    hit_idx, hit_dat, rd_only;
  byte_t   idx_q, dat_rdata, gpio_base;
  logic [NB-1:0] gpio_en, sel;
  byte_t   gpio_rd;
  rd_src_e src;

  assign hit_idx = (bus_addr == CFG_BASE);
  assign hit_dat = (bus_addr == CFG_BASE + AW'(1));
  assign rd_only = bus_rd && !bus_wr;

  sio_cfg_regs #(.CHIP_ID(CHIP_ID), .NBYTE(NB)) cfg_i (
    .clk       (clk),
    .rst       (rst),
    .idx_wr    (bus_wr && hit_idx),
    .idx_rd    (rd_only && hit_idx),
    .dat_wr    (bus_wr && hit_dat),
    .wdata     (bus_wdata),
    .idx_q     (idx_q),
    .dat_rdata (dat_rdata),
    .gpio_base (gpio_base),
    .gpio_en   (gpio_en)
  );

  sio_gpio_decode #(.AW(AW), .NBYTE(NB)) dec_i (
    .addr      (bus_addr),
    .cfg_claim (hit_idx || hit_dat),
    .base_reg  (gpio_base),
    .en        (gpio_en),
    .sel       (sel)
  );

  sio_gpio_latch #(.NBYTE(NB)) lat_i (
    .clk   (clk),
    .rst   (rst),
    .wr    (bus_wr),
    .sel   (sel),
    .wdata (bus_wdata),
    .lat   (gpio_latch)
  );

  always_comb begin
    gpio_rd = 8'hFF;
    for (int k = 0; k < NB; k++)
      if (sel[k]) gpio_rd = gpio_latch[k*8 +: 8];
  end

  always_comb begin
    if (hit_idx)      src = SRC_IDX;
    else if (hit_dat) src = SRC_DAT;
    else if (|sel)    src = SRC_GPIO;
    else              src = SRC_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      gpio_hit  <= 1'b0;
    end else begin
      gpio_hit <= (bus_wr || bus_rd) && (|sel);
      if (rd_only) begin
        unique case (src)
          SRC_IDX:  bus_rdata <= idx_q;
          SRC_DAT:  bus_rdata <= dat_rdata;
          SRC_GPIO: bus_rdata <= gpio_rd;
          default:  bus_rdata <= 8'hFF;
        endcase
      end
    end
  end

  // R8: configuration addresses never raise the GPIO hit flag
  p_hit_not_cfg_r8: assert property (@(posedge clk) disable iff (rst)
    gpio_hit |-> $past(!hit_idx && !hit_dat));

  // R9: read data holds when no read-only strobe was seen
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_only) |-> $stable(bus_rdata));

  // R3: the identification register always reads back its fixed value
  p_chip_id_r3: assert property (@(posedge clk) disable iff (rst)
    $past(rd_only && hit_dat && idx_q == 8'd8) |-> (bus_rdata == CHIP_ID));

  // R6: a decoded GPIO byte must have its enable bit set
  p_sel_needs_en_r6: assert property (@(posedge clk) disable iff (rst)
    (sel & ~gpio_en) == '0);
endmodule

// File: tb/sio_cfg_gpio_tb_top.sv
module sio_cfg_gpio_tb_top;
  localparam logic [15:0] IDX = 16'h0398;
  localparam logic [15:0] DAT = 16'h0399;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        hit;
  logic [15:0] latch;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sio_cfg_gpio dut_i (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .gpio_hit(hit), .gpio_latch(latch)
  );

  // behavioural reference model
  logic [7:0]  m_reg [0:28];
  logic [7:0]  m_idx, m_rdata, m_lat0, m_lat1;
  logic        m_armed, m_hit;
  logic        ci, cd, s0, s1;
  logic [15:0] gb;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 29; i++) m_reg[i] = 8'h00;
      m_reg[8] = 8'h70;
      m_idx = 0; m_armed = 0; m_rdata = 0; m_hit = 0; m_lat0 = 0; m_lat1 = 0;
    end else begin
      ci = (addr == IDX);
      cd = (addr == DAT);
      gb = {6'b0, m_reg[15], 2'b00};
      s0 = !ci && !cd && m_reg[18][4] && (addr == gb);
      s1 = !ci && !cd && m_reg[18][5] && (addr == gb + 16'd1);
      if (rd && !wr) begin
        if (ci)      m_rdata = m_idx;
        else if (cd) m_rdata = (m_idx < 29) ? m_reg[m_idx] : 8'hFF;
        else if (s0) m_rdata = m_lat0;
        else if (s1) m_rdata = m_lat1;
        else         m_rdata = 8'hFF;
      end
      m_hit = (wr || rd) && (s0 || s1);
      if (wr && s0) m_lat0 = wdata;
      if (wr && s1) m_lat1 = wdata;
      if (ci && (wr || rd)) begin
        m_armed = 0;
        if (wr) m_idx = wdata;
      end else if (cd && wr) begin
        if (m_armed && m_idx < 29 && m_idx != 8 && m_idx != 24)
          m_reg[m_idx] = (m_idx == 0) ? (wdata & 8'h5F) : wdata;
        m_armed = !m_armed;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (rdata !== m_rdata) begin
        errors++;
        $display("FAIL R9 model rdata actual=%02h expected=%02h", rdata, m_rdata);
      end
      checks++;
      if (hit !== m_hit) begin
        errors++;
        $display("FAIL R8 model hit actual=%0b expected=%0b", hit, m_hit);
      end
      checks++;
      if (latch !== {m_lat1, m_lat0}) begin
        errors++;
        $display("FAIL R7 model latch actual=%04h expected=%04h", latch, {m_lat1, m_lat0});
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic op(input logic [15:0] a, input logic w, input logic r, input logic [7:0] d);
    addr = a; wr = w; rd = r; wdata = d;
    @(negedge clk);
    wr = 0; rd = 0;
  endtask

  task automatic cfg_set(input logic [7:0] i, input logic [7:0] v);
    op(IDX, 1, 0, i);
    op(DAT, 1, 0, v);
    op(DAT, 1, 0, v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R5 reset rdata", rdata, 8'h00);
    chk("R5 reset hit", hit, 0);
    chk("R5 reset latch", latch, 16'h0000);
    op(IDX, 1, 0, 8'h08); op(DAT, 0, 1, 0);
    chk("R5 chip id after reset", rdata, 8'h70);
    op(IDX, 0, 1, 0);
    chk("R2 index read", rdata, 8'h08);

    op(IDX, 1, 0, 8'h0F);
    op(DAT, 1, 0, 8'h41);
    op(DAT, 0, 1, 0);
    chk("R1 single write no commit", rdata, 8'h00);
    op(DAT, 1, 0, 8'h41);
    op(DAT, 0, 1, 0);
    chk("R1 second write commits", rdata, 8'h41);

    op(DAT, 1, 0, 8'h99);
    op(IDX, 1, 0, 8'h0F);
    op(DAT, 1, 0, 8'h99);
    op(DAT, 0, 1, 0);
    chk("R2 index access disarms", rdata, 8'h41);
    op(IDX, 0, 1, 0);
    chk("R2 index readback", rdata, 8'h0F);

    cfg_set(8'h00, 8'hFF);
    op(DAT, 0, 1, 0);
    chk("R4 reg0 mask", rdata, 8'h5F);

    cfg_set(8'h08, 8'h00); op(DAT, 0, 1, 0);
    chk("R3 reg8 read-only", rdata, 8'h70);
    cfg_set(8'h18, 8'hAA); op(DAT, 0, 1, 0);
    chk("R3 reg24 read-only", rdata, 8'h00);
    cfg_set(8'h1C, 8'h3C); op(DAT, 0, 1, 0);
    chk("R3 reg28 writable", rdata, 8'h3C);
    cfg_set(8'h1D, 8'h55); op(DAT, 0, 1, 0);
    chk("R3 index 29 reads FF", rdata, 8'hFF);
    op(IDX, 1, 0, 8'h1C); op(DAT, 0, 1, 0);
    chk("R3 reg28 untouched", rdata, 8'h3C);

    op(16'h0104, 1, 0, 8'h5A);
    chk("R8 disabled no hit", hit, 0);
    chk("R7 disabled no write", latch, 16'h0000);
    op(16'h0104, 0, 1, 0);
    chk("R7 disabled reads FF", rdata, 8'hFF);

    cfg_set(8'h12, 8'h10);
    op(16'h0104, 1, 0, 8'h5A);
    chk("R8 hit on enabled byte", hit, 1);
    chk("R7 byte0 latch", latch[7:0], 8'h5A);
    op(16'h0104, 0, 1, 0);
    chk("R7 byte0 readback", rdata, 8'h5A);
    op(16'h0105, 0, 1, 0);
    chk("R6 byte1 still off", rdata, 8'hFF);
    op(16'h0105, 1, 0, 8'h11);
    chk("R6 byte1 write ignored", latch[15:8], 8'h00);

    op(DAT, 1, 0, 8'h30); op(DAT, 1, 0, 8'h30);
    op(16'h0105, 1, 0, 8'hC3);
    op(16'h0105, 0, 1, 0);
    chk("R6 byte1 enabled", rdata, 8'hC3);
    chk("R7 both latches", latch, 16'hC35A);

    cfg_set(8'h0F, 8'h40);
    op(16'h0104, 0, 1, 0);
    chk("R6 old window gone", rdata, 8'hFF);
    op(16'h0100, 0, 1, 0);
    chk("R6 new base byte0", rdata, 8'h5A);
    op(16'h0101, 0, 1, 0);
    chk("R6 new base byte1", rdata, 8'hC3);

    op(DAT, 1, 0, 8'hE6); op(DAT, 1, 0, 8'hE6);
    op(IDX, 1, 0, 8'h0F);
    chk("R8 overlap write no hit", hit, 0);
    chk("R8 overlap latch kept", latch, 16'hC35A);
    op(IDX, 0, 1, 0);
    chk("R8 overlap index wins", rdata, 8'h0F);
    chk("R8 overlap read no hit", hit, 0);
    op(DAT, 0, 1, 0);
    chk("R8 overlap data port", rdata, 8'hE6);

    op(DAT, 1, 0, 8'h40); op(DAT, 1, 0, 8'h40);
    op(16'h0100, 1, 1, 8'h77);
    chk("R9 write wins rdata held", rdata, 8'hE6);
    chk("R9 write wins latch", latch[7:0], 8'h77);
    @(negedge clk);
    chk("R9 idle hold", rdata, 8'hE6);
    op(16'h0200, 0, 1, 0);
    chk("R9 unclaimed reads FF", rdata, 8'hFF);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R5 watchdog actual=timeout expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule